// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This controller runs on the host side of a parallel flash. It works out when an embedded program or erase operation has finished. The device's status byte flips one bit on every read while an operation runs. The poller reads that byte in pairs over a request/acknowledge read channel and compares the toggle bit between the two reads of each pair. A bit that holds its value means the device has gone quiet. A bit that changes means work is still in progress. The device's timeout flag can rise just as toggling stops, so the poller takes one more pair of reads when that flag is seen, before it declares a failure.

A second mode answers an erase-status question with a single pair of reads. It reports whether the device is actively erasing or erase-suspended, and whether the sector being read is one of those selected for erase. The result is a 3-bit code. A one-cycle `done` pulse marks it, and the code holds until the next accepted start. A poll-pair limit makes sure every request finishes, even when the device never settles.

Top module: `tgp_poll_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `rd_req` are low and `result` is 0 (no result).
- R2: A `start` pulse while idle raises `busy` and clears `result` to 0 on the next cycle, and `rd_req` rises in that same cycle. The value of `erase_mode` is latched at that start. A `start` while busy has no effect on the reads issued or the final result. `rd_req` is low whenever `busy` is low.
- R3: A read transfers in a cycle where `rd_req` and `rd_ack` are both high, and `rd_data` is sampled in that cycle. `rd_req` stays high until the transfer. At most one read is in flight.
- R4: In completion mode, if bit 6 of `rd_data` (the toggle bit) has the same value in both reads of a pair, the operation ends with code 1 (complete).
- R5: In completion mode, if the toggle bit differs within a pair and bit 5 (the timeout flag) of the second read is high, one more pair is read at once. The operation ends with code 1 if the toggle bit is equal in that pair, and with code 2 (timed out) otherwise.
- R6: In completion mode, if the toggle bit differs and bit 5 is low, `rd_req` stays low for exactly GAP_CYCLES cycles before the next pair begins.
- R7: If MAX_PAIRS ordinary pairs all show toggling with bit 5 low, the operation ends with code 3 (limit reached) after exactly 2·MAX_PAIRS reads.
- R8: In erase-status mode exactly two reads are made. The result is 4 + 2·(bit 6 equal) + (bit 2 equal): 4 means erasing with the sector selected, 5 erasing with the sector not selected, 6 suspended with the sector selected, 7 suspended with the sector not selected.
- R9: `done` pulses for exactly one cycle, with `busy` low and a nonzero `result` in that cycle. `result` then stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (one-cycle pulse) |
| erase_mode | input | 1 | 0: completion poll, 1: erase-status query |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 3 | Result code (see R4, R5, R7, R8) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; data valid this cycle |
| rd_data | input | DW | Status byte returned by the read |

## Verification
The assertions assume that the read responder never raises `rd_ack` unless `rd_req` is high, and that it returns the status byte in the acknowledge cycle. The bench responder keeps to this. It acknowledges only requests it has seen, after a fixed latency of 0 to 2 cycles. The status byte it returns is computed from the read index. The toggle bit alternates until a chosen stop index and then holds. The timeout flag rises at a chosen index. The other bits also change from read to read, so that reading the wrong bit position gives a different result. `start` is pulsed for a single cycle, and one run pulses it again while busy to check that it has no effect.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

  typedef enum logic [2:0] {
    RES_NONE          = 3'd0,
    RES_OK            = 3'd1,
    RES_TIMEOUT       = 3'd2,
    RES_LIMIT         = 3'd3,
    RES_ERS_ACT_SEL   = 3'd4,
    RES_ERS_ACT_UNSEL = 3'd5,
    RES_ERS_SUS_SEL   = 3'd6,
    RES_ERS_SUS_UNSEL = 3'd7
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_GAP,
    ST_RC_A,
    ST_RC_B
  } st_e;

  // Erase-status code: base 4, +2 when the mode bit held still, +1 when
  // the sector bit held still.
  function automatic res_e erase_code(input logic mode_moved, input logic sect_moved);
    logic [2:0] c;
    c = 3'd4;
    if (!mode_moved) c = c + 3'd2;
    if (!sect_moved) c = c + 3'd1;
    return res_e'(c);
  endfunction

  // Verdict of a recheck pair.
  function automatic res_e recheck_code(input logic still_moving);
    return still_moving ? RES_TIMEOUT : RES_OK;
  endfunction

endpackage

// File: rtl/tgp_rd_port.sv
module tgp_rd_port #(
  parameter int DW = 8
) (
  input  logic          want,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic          xfer,
  output logic [DW-1:0] xfer_data
);
  assign rd_req    = want;
  assign xfer      = want & rd_ack;
  assign xfer_data = rd_data;
endmodule

// File: rtl/tgp_pair_cmp.sv
module tgp_pair_cmp #(
  parameter int DW      = 8,
  parameter int TGL_BIT = 6,
  parameter int TMO_BIT = 5,
  parameter int SEC_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] data,
  output logic          tgl_moved,
  output logic          sec_moved,
  output logic          tmo_seen
);
  logic tgl_first_q, sec_first_q;
  logic unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_first_q <= 1'b0;
      sec_first_q <= 1'b0;
    end else if (capture) begin
      tgl_first_q <= data[TGL_BIT];
      sec_first_q <= data[SEC_BIT];
    end
  end

  assign tgl_moved   = tgl_first_q ^ data[TGL_BIT];
  assign sec_moved   = sec_first_q ^ data[SEC_BIT];
  assign tmo_seen    = data[TMO_BIT];
  assign unused_bits = ^data;
endmodule

// File: rtl/tgp_gap_timer.sv
module tgp_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  generate
    if (GAP_CYCLES == 0) begin : g_nogap
      assign expired = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(GAP_CYCLES + 1);
      localparam logic [GW-1:0] RELOAD = GW'(GAP_CYCLES - 1);
      logic [GW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= RELOAD;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign expired = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/tgp_poll_ctrl.sv
module tgp_poll_ctrl #(
  parameter int DW         = 8,
  parameter int TGL_BIT    = 6,
  parameter int TMO_BIT    = 5,
  parameter int SEC_BIT    = 2,
  parameter int MAX_PAIRS  = 256,
  parameter int GAP_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          erase_mode,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data
);
  import tgp_pkg::*;

  localparam int PW = $clog2(MAX_PAIRS + 1);
  localparam logic [PW-1:0] LAST_PAIR = PW'(MAX_PAIRS - 1);
  localparam bit HAS_GAP = (GAP_CYCLES > 0);

  st_e           st_q;
  res_e          res_q;
  logic          done_q;
  logic          ers_q;
  logic [PW-1:0] pairs_q;

  // named internal events
  logic          want;
  logic          xfer;
  logic [DW-1:0] xfer_data;
  logic          first_capture;
  logic          tgl_moved, sec_moved, tmo_seen;
  logic          gap_active, gap_load, gap_expired;
  logic          accept;

  assign want = (st_q == ST_RD_A) || (st_q == ST_RD_B) ||
                (st_q == ST_RC_A) || (st_q == ST_RC_B);
  assign first_capture = xfer && ((st_q == ST_RD_A) || (st_q == ST_RC_A));
  assign gap_active    = (st_q == ST_GAP);
  assign accept        = start && (st_q == ST_IDLE);
  assign gap_load      = xfer && (st_q == ST_RD_B) && !ers_q && tgl_moved &&
                         !tmo_seen && (pairs_q != LAST_PAIR);

  tgp_rd_port #(.DW(DW)) u_port (
    .want(want), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .xfer(xfer), .xfer_data(xfer_data)
  );

  tgp_pair_cmp #(.DW(DW), .TGL_BIT(TGL_BIT), .TMO_BIT(TMO_BIT), .SEC_BIT(SEC_BIT)) u_cmp (
    .clk(clk), .rst_n(rst_n), .capture(first_capture), .data(xfer_data),
    .tgl_moved(tgl_moved), .sec_moved(sec_moved), .tmo_seen(tmo_seen)
  );

  tgp_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .tick(gap_active),
    .expired(gap_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      res_q   <= RES_NONE;
      done_q  <= 1'b0;
      ers_q   <= 1'b0;
      pairs_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          res_q   <= RES_NONE;
          ers_q   <= erase_mode;
          pairs_q <= '0;
          st_q    <= ST_RD_A;
        end
        ST_RD_A: if (xfer) st_q <= ST_RD_B;
        ST_RD_B: if (xfer) begin
          if (ers_q) begin
            res_q  <= erase_code(tgl_moved, sec_moved);
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (!tgl_moved) begin
            res_q  <= RES_OK;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (tmo_seen) begin
            st_q <= ST_RC_A;
          end else if (pairs_q == LAST_PAIR) begin
            res_q  <= RES_LIMIT;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            pairs_q <= pairs_q + 1'b1;
            st_q    <= HAS_GAP ? ST_GAP : ST_RD_A;
          end
        end
        ST_GAP:  if (gap_expired) st_q <= ST_RD_A;
        ST_RC_A: if (xfer) st_q <= ST_RC_B;
        ST_RC_B: if (xfer) begin
          res_q  <= recheck_code(tgl_moved);
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/tgp_poll_chk.sv
module tgp_poll_chk #(
  parameter int MAX_PAIRS = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       erase_mode,
  input logic       busy,
  input logic       done,
  input logic [2:0] result,
  input logic       rd_req,
  input logic       rd_ack,
  input logic       gap_active
);
  localparam logic [31:0] RD_CAP = 32'(2 * MAX_PAIRS + 2);

  logic [31:0] rd_cnt;
  logic        ers_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      ers_seen <= 1'b0;
    end else if (start && !busy) begin
      rd_cnt   <= '0;
      ers_seen <= erase_mode;
    end else if (rd_req && rd_ack) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req); // R2
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> !rd_req); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && result != 3'd0); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result)); // R9
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= RD_CAP); // R7
  AST_ERASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    done && ers_seen |-> rd_cnt == 32'd2 && result[2]); // R8
  AST_POLL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ers_seen |-> !result[2]); // R4
endmodule

bind tgp_poll_ctrl tgp_poll_chk #(.MAX_PAIRS(MAX_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .erase_mode(erase_mode),
  .busy(busy), .done(done), .result(result), .rd_req(rd_req),
  .rd_ack(rd_ack), .gap_active(gap_active)
);

// File: tb/tb_tgp_poll_ctrl.sv
module tb_tgp_poll_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int MAXP  = 4;
  localparam int GAP   = 3;
  localparam int NEVER = 99;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          erase_mode = 1'b0;
  logic          busy, done, rd_req;
  logic [2:0]    result;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // responder scenario
  int sc_stop = 0;
  int sc_t5 = NEVER;
  bit sc_dq2 = 0;
  int sc_lat = 0;
  int nreads = 0;
  int wcnt = 0;
  int low_run = 0;

  tgp_poll_ctrl #(.DW(DW), .MAX_PAIRS(MAXP), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_mode(erase_mode),
    .busy(busy), .done(done), .result(result), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] status_byte(input int k);
    logic [7:0] b;
    int m;
    m = (k < sc_stop) ? k : sc_stop;
    b[7] = k[0];
    b[6] = m[0];
    b[5] = (k >= sc_t5);
    b[4] = 1'b1;
    b[3] = ~k[0];
    b[2] = sc_dq2 ? k[0] : 1'b0;
    b[1:0] = k[1:0];
    return b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // read responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        nreads++;
        wcnt = 0;
      end
      if (rd_req && wcnt >= sc_lat) begin
        rd_ack  = 1'b1;
        rd_data = status_byte(nreads);
      end else begin
        rd_ack = 1'b0;
        if (rd_req) wcnt++;
      end
    end
  end

  // R6: idle stretch between pairs while busy
  initial begin
    forever begin
      @(negedge clk);
      if (!busy) low_run = 0;
      else if (!rd_req) low_run++;
      else begin
        if (low_run > 0) check("R6 gap length", low_run, GAP);
        low_run = 0;
      end
    end
  end

  function automatic void predict_poll(input int stop, input int t5,
                                       output int code, output int nrd);
    code = -1;
    nrd = 0;
    for (int p = 0; p < MAXP && code < 0; p++) begin
      int k;
      k = 2 * p;
      if (k >= stop) begin code = 1; nrd = k + 2; end
      else if (k + 1 >= t5) begin code = (k + 2 >= stop) ? 1 : 2; nrd = k + 4; end
      else if (p == MAXP - 1) begin code = 3; nrd = k + 2; end
    end
  endfunction

  task automatic run(input bit ers, input int stop, input int t5, input bit dq2,
                     input int lat, input bit extra_start,
                     input int exp_code, input int exp_rd, input string tag);
    int cyc;
    int hold;
    sc_stop = stop; sc_t5 = t5; sc_dq2 = dq2; sc_lat = lat;
    @(negedge clk);
    nreads = 0;
    start = 1'b1;
    erase_mode = ers;
    @(negedge clk);
    start = 1'b0;
    erase_mode = ~ers;
    check("R2 busy after start", busy, 1);
    check("R2 result cleared", result, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (extra_start && cyc == 3) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check({tag, " done seen"}, done, 1);
    check({tag, " result"}, result, exp_code);
    check("R9 busy low at done", busy, 0);
    hold = result;
    repeat (3) @(negedge clk);
    check("R9 result held", result, hold);
    check("R9 done one cycle", done, 0);
    check("R3 read count", nreads, exp_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int code, nrd;
    string tag;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    check("R1 rd_req", rd_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // completion mode sweep: R4, R5, R6, R7
    for (int lat = 0; lat < 3; lat++)
      for (int stop = 0; stop < 12; stop++)
        for (int t = 0; t < 13; t++) begin
          int t5;
          t5 = (t == 12) ? NEVER : t;
          predict_poll(stop, t5, code, nrd);
          if (code == 3) tag = "R7";
          else if (nrd > 2 && (nrd % 2 == 0) && code == 2) tag = "R5";
          else if (code == 1 && stop > 0 && t5 <= stop) tag = "R5";
          else tag = "R4";
          run(1'b0, stop, t5, 1'b0, lat, 1'b0, code, nrd, tag);
        end

    // erase-status mode: R8
    for (int lat = 0; lat < 3; lat++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++) begin
          int stop;
          stop = (s == 0) ? 0 : 5;
          code = 4 + ((stop == 0) ? 2 : 0) + ((d == 1) ? 0 : 1);
          run(1'b1, stop, 0, d[0], lat, 1'b0, code, 2, "R8");
        end

    // start while busy ignored: R2
    run(1'b0, NEVER, NEVER, 1'b0, 1, 1'b1, 3, 2 * MAXP, "R2 start ignored");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule